// File: doc/BRIEF.md
# Coherence Epoch Tracker

This block sits beside a private cache controller and keeps, for every cache frame (set and way), a record of the interval during which the cache holds permission on the resident block. Such an interval is called an epoch. It is either read-only or read-write. When the controller gains permission, the tracker opens an entry with the current logical time and a CRC-32 of the block contents. When permission is dropped, the tracker closes the entry and sends out a report that holds both ends of the interval. A report is also sent when the controller upgrades from read-only to read-write, because that closes one epoch and opens another. The contents are streamed in on a word bus, one word per cycle, after each permission event is accepted.

Independently, every committed load or store is checked against the entry of the frame it names, in the cycle it is presented. There is no handshake on that path, so normal cache traffic is never stalled. An access that falls outside a suitable epoch latches a sticky error flag and records the address of the first offender.

A three-state machine sequences each permission event. ST_IDLE accepts an event when the report queue has room (transition T_ACCEPT to ST_HASH). ST_HASH absorbs the block words; T_LAST_WORD moves it to ST_COMMIT when the final word arrives. ST_COMMIT updates the entry and queues any report, then returns to ST_IDLE through T_DONE. Reports leave through a valid/ready port backed by a small queue. A full queue holds off new permission events.

Top module: `coh_epoch_tracker`

## Requirements
- R1: After reset, evt_ready is 1, rpt_valid is 0, err_flag is 0 and err_addr is 0. Every entry is empty, so any access afterwards is illegal until a grant is made.
- R2: An event is accepted at a rising edge where evt_valid and evt_ready are both 1, and now_ts is sampled at that edge. Exactly BLK_WORDS words are then taken on edges with dat_valid high; a word presented while dat_valid is low is ignored. At the edge after the last word, the entry is updated and any report is queued. evt_ready stays 0 from acceptance until that update. Event encoding on evt_kind: 0 grants read-only, 1 grants read-write, 2 revokes, 3 upgrades.
- R3: The block hash is a CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, with no reflection and no final inversion. It is computed word by word in arrival order, taking each word from bit 31 down to bit 0.
- R4: A grant opens the entry with its type, the sampled time as begin time, and the block hash as begin hash. A grant on an entry that is already open replaces that entry without a report.
- R5: A revoke of an open entry closes it and queues one report. The report carries: rpt_rw, the entry's type (1 means read-write); the entry's set and way; its begin time and begin hash; the sampled time as end time; and the block hash as end hash. A revoke of an empty entry queues nothing.
- R6: An upgrade queues the report for the open entry, if there is one, and opens a read-write entry in the same update. The new entry's begin time and begin hash equal the end time and end hash of the closed epoch.
- R7: A load is legal if its entry is open. A store is legal only if its entry is open and read-write. The check uses the entry contents as they were before any update made at the same edge.
- R8: An illegal access sets err_flag at the next edge. err_flag then stays 1 until reset, and err_addr holds the address of the first illegal access only.
- R9: Reports leave in the order they were queued. While rpt_valid is 1 and rpt_ready is 0, every report output stays unchanged.
- R10: While the report queue holds FIFO_DEPTH reports, evt_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Permission event offered |
| evt_ready | output | 1 | Event can be accepted |
| evt_kind | input | 2 | 0 grant RO, 1 grant RW, 2 revoke, 3 upgrade |
| evt_set | input | $clog2(SETS) | Set of the frame |
| evt_way | input | $clog2(WAYS) | Way of the frame |
| now_ts | input | TS_W | Global logical time |
| dat_valid | input | 1 | Block word present |
| dat_word | input | 32 | Block word |
| acc_valid | input | 1 | Committed access present |
| acc_store | input | 1 | 1 for store, 0 for load |
| acc_set | input | $clog2(SETS) | Set of the accessed frame |
| acc_way | input | $clog2(WAYS) | Way of the accessed frame |
| acc_addr | input | ADDR_W | Block address of the access |
| rpt_valid | output | 1 | Report available |
| rpt_ready | input | 1 | Report consumed |
| rpt_rw | output | 1 | Closed epoch was read-write |
| rpt_set | output | $clog2(SETS) | Set of the closed entry |
| rpt_way | output | $clog2(WAYS) | Way of the closed entry |
| rpt_begin_ts | output | TS_W | Begin time |
| rpt_begin_hash | output | 32 | Begin hash |
| rpt_end_ts | output | TS_W | End time |
| rpt_end_hash | output | 32 | End hash |
| err_flag | output | 1 | Sticky illegal-access flag |
| err_addr | output | ADDR_W | Address of first illegal access |

## Verification
The hardest state to reach from the ports is a full report queue that holds off a pending permission event. To get there, the stimulus keeps rpt_ready low across two revokes and then offers a third event. It checks that the event stays unaccepted while the queued reports hold still, and then drains them one at a time to confirm their order. The upgrade path is also hard to observe, because its two epochs share a time and a hash. The stimulus follows an upgrade with a revoke and compares the two reports against each other. The same upgrade is followed by a store, which shows that the entry changed type within a single update.

// File: rtl/epoch_pkg.sv
package epoch_pkg;

    localparam int          HASH_W    = 32;
    localparam logic [31:0] HASH_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] HASH_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        EV_GRANT_RO = 2'd0,
        EV_GRANT_RW = 2'd1,
        EV_REVOKE   = 2'd2,
        EV_UPGRADE  = 2'd3
    } ev_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HASH   = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_t;

endpackage

// File: rtl/epoch_crc.sv
module epoch_crc
    import epoch_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              step,
    input  logic [WORD_W-1:0] word,
    output logic [HASH_W-1:0] crc
);

    logic [HASH_W-1:0] crc_q;
    logic [HASH_W-1:0] crc_next;
    logic              fb;

    always_comb begin
        crc_next = crc_q;
        fb       = 1'b0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb       = crc_next[HASH_W-1] ^ word[i];
            crc_next = {crc_next[HASH_W-2:0], 1'b0};
            if (fb) begin
                crc_next = crc_next ^ HASH_POLY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= HASH_SEED;
        end else if (init) begin
            crc_q <= HASH_SEED;
        end else if (step) begin
            crc_q <= crc_next;
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/epoch_table.sv
module epoch_table
    import epoch_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TS_W    = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_open,
    input  logic              wr_rw,
    input  logic [TS_W-1:0]   wr_ts,
    input  logic [HASH_W-1:0] wr_hash,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_open,
    output logic              rd_rw,
    output logic [TS_W-1:0]   rd_ts,
    output logic [HASH_W-1:0] rd_hash,
    input  logic [IDX_W-1:0]  chk_idx,
    output logic              chk_open,
    output logic              chk_rw
);

    logic              open_q [ENTRIES];
    logic              rw_q   [ENTRIES];
    logic [TS_W-1:0]   ts_q   [ENTRIES];
    logic [HASH_W-1:0] hash_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                open_q[e] <= 1'b0;
                rw_q[e]   <= 1'b0;
                ts_q[e]   <= '0;
                hash_q[e] <= '0;
            end
        end else if (wr_en) begin
            open_q[wr_idx] <= wr_open;
            rw_q[wr_idx]   <= wr_rw;
            ts_q[wr_idx]   <= wr_ts;
            hash_q[wr_idx] <= wr_hash;
        end
    end

    always_comb begin
        rd_open  = open_q[rd_idx];
        rd_rw    = rw_q[rd_idx];
        rd_ts    = ts_q[rd_idx];
        rd_hash  = hash_q[rd_idx];
        chk_open = open_q[chk_idx];
        chk_rw   = rw_q[chk_idx];
    end

endmodule

// File: rtl/epoch_report_fifo.sv
module epoch_report_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    output logic              full,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign out_valid = (count_q != '0);
    assign full      = (count_q == CNT_W'(DEPTH));
    assign pop       = out_valid && out_ready;
    assign out_data  = mem_q[rd_ptr_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                mem_q[e] <= '0;
            end
        end else begin
            if (push) begin
                mem_q[wr_ptr_q] <= push_data;
                wr_ptr_q        <= bump(wr_ptr_q);
            end
            if (pop) begin
                rd_ptr_q <= bump(rd_ptr_q);
            end
            if (push && !pop) begin
                count_q <= count_q + 1'b1;
            end else if (pop && !push) begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R10

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9

endmodule

// File: rtl/coh_epoch_tracker.sv
module coh_epoch_tracker
    import epoch_pkg::*;
#(
    parameter int SETS       = 8,
    parameter int WAYS       = 2,
    parameter int TS_W       = 16,
    parameter int ADDR_W     = 16,
    parameter int BLK_WORDS  = 4,
    parameter int FIFO_DEPTH = 2,
    localparam int SET_W     = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [1:0]        evt_kind,
    input  logic [SET_W-1:0]  evt_set,
    input  logic [WAY_W-1:0]  evt_way,
    input  logic [TS_W-1:0]   now_ts,
    input  logic              dat_valid,
    input  logic [31:0]       dat_word,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic [SET_W-1:0]  acc_set,
    input  logic [WAY_W-1:0]  acc_way,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              rpt_valid,
    input  logic              rpt_ready,
    output logic              rpt_rw,
    output logic [SET_W-1:0]  rpt_set,
    output logic [WAY_W-1:0]  rpt_way,
    output logic [TS_W-1:0]   rpt_begin_ts,
    output logic [31:0]       rpt_begin_hash,
    output logic [TS_W-1:0]   rpt_end_ts,
    output logic [31:0]       rpt_end_hash,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);

    localparam int ENTRIES = SETS * WAYS;
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNT_W   = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
    localparam int RPT_W   = 1 + SET_W + WAY_W + 2 * TS_W + 2 * HASH_W;

    // sequencer state
    seq_state_t        state_q, state_d;
    ev_kind_t          kind_q;
    logic [SET_W-1:0]  set_q;
    logic [WAY_W-1:0]  way_q;
    logic [TS_W-1:0]   ts_q;
    logic [CNT_W-1:0]  cnt_q;

    // datapath controls (outputs process)
    logic              accept;
    logic              crc_step;
    logic              tbl_wr;
    logic              tbl_open;
    logic              tbl_rw;
    logic [TS_W-1:0]   tbl_ts;
    logic [HASH_W-1:0] tbl_hash;
    logic              rpt_push;
    logic              last_word;

    // shared signals
    logic [HASH_W-1:0] crc;
    logic              fifo_full;
    logic [IDX_W-1:0]  ev_idx;
    logic [IDX_W-1:0]  ac_idx;
    logic              ent_open;
    logic              ent_rw;
    logic [TS_W-1:0]   ent_ts;
    logic [HASH_W-1:0] ent_hash;
    logic              chk_open;
    logic              chk_rw;
    logic              illegal;
    logic [RPT_W-1:0]  push_word;
    logic [RPT_W-1:0]  head_word;

    function automatic logic [IDX_W-1:0] frame_index(input logic [SET_W-1:0] s,
                                                     input logic [WAY_W-1:0] w);
        return IDX_W'(int'(s) * WAYS + int'(w));
    endfunction

    assign ev_idx    = frame_index(set_q, way_q);
    assign ac_idx    = frame_index(acc_set, acc_way);
    assign last_word = dat_valid && (cnt_q == CNT_W'(BLK_WORDS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_ACCEPT, T_LAST_WORD, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (evt_valid && !fifo_full) state_d = ST_HASH;
            ST_HASH:   if (last_word)               state_d = ST_COMMIT;
            ST_COMMIT:                              state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        evt_ready = 1'b0;
        accept    = 1'b0;
        crc_step  = 1'b0;
        tbl_wr    = 1'b0;
        tbl_open  = ent_open;
        tbl_rw    = ent_rw;
        tbl_ts    = ent_ts;
        tbl_hash  = ent_hash;
        rpt_push  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                evt_ready = !fifo_full;
                accept    = evt_valid && !fifo_full;
            end
            ST_HASH: begin
                crc_step = dat_valid;
            end
            ST_COMMIT: begin
                tbl_wr = 1'b1;
                unique case (kind_q)
                    EV_GRANT_RO, EV_GRANT_RW: begin
                        tbl_open = 1'b1;
                        tbl_rw   = (kind_q == EV_GRANT_RW);
                        tbl_ts   = ts_q;
                        tbl_hash = crc;
                    end
                    EV_REVOKE: begin
                        tbl_open = 1'b0;
                        rpt_push = ent_open;
                    end
                    EV_UPGRADE: begin
                        tbl_open = 1'b1;
                        tbl_rw   = 1'b1;
                        tbl_ts   = ts_q;
                        tbl_hash = crc;
                        rpt_push = ent_open;
                    end
                    default: tbl_wr = 1'b0;
                endcase
            end
            default: ;
        endcase
    end

    // event capture and word counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= EV_GRANT_RO;
            set_q  <= '0;
            way_q  <= '0;
            ts_q   <= '0;
            cnt_q  <= '0;
        end else begin
            if (accept) begin
                kind_q <= ev_kind_t'(evt_kind);
                set_q  <= evt_set;
                way_q  <= evt_way;
                ts_q   <= now_ts;
                cnt_q  <= '0;
            end else if (crc_step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    epoch_crc #(.WORD_W(32)) i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (accept),
        .step  (crc_step),
        .word  (dat_word),
        .crc   (crc)
    );

    epoch_table #(.ENTRIES(ENTRIES), .TS_W(TS_W)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_idx   (ev_idx),
        .wr_open  (tbl_open),
        .wr_rw    (tbl_rw),
        .wr_ts    (tbl_ts),
        .wr_hash  (tbl_hash),
        .rd_idx   (ev_idx),
        .rd_open  (ent_open),
        .rd_rw    (ent_rw),
        .rd_ts    (ent_ts),
        .rd_hash  (ent_hash),
        .chk_idx  (ac_idx),
        .chk_open (chk_open),
        .chk_rw   (chk_rw)
    );

    assign push_word = {ent_rw, set_q, way_q, ent_ts, ent_hash, ts_q, crc};

    epoch_report_fifo #(.DATA_W(RPT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rpt_push),
        .push_data (push_word),
        .full      (fifo_full),
        .out_valid (rpt_valid),
        .out_ready (rpt_ready),
        .out_data  (head_word)
    );

    assign {rpt_rw, rpt_set, rpt_way, rpt_begin_ts, rpt_begin_hash,
            rpt_end_ts, rpt_end_hash} = head_word;

    // access legality and sticky error capture
    assign illegal = acc_valid && (!chk_open || (acc_store && !chk_rw));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_addr <= '0;
        end else if (illegal && !err_flag) begin
            err_flag <= 1'b1;
            err_addr <= acc_addr;
        end
    end

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_ready |=> !evt_ready); // R2

    AST_STORE_NEEDS_RW: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_store && chk_open && !chk_rw && !err_flag
        |=> err_flag && err_addr == $past(acc_addr)); // R7

    AST_EMPTY_ACCESS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !chk_open |=> err_flag); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag && $stable(err_addr)); // R8

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !evt_ready); // R10

endmodule

// File: tb/test_coh_epoch_tracker.sv
module test_coh_epoch_tracker;

    localparam int DEPTH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [1:0]  evt_kind = 2'd0;
    logic [2:0]  evt_set = '0;
    logic        evt_way = 1'b0;
    logic [15:0] now_ts = '0;
    logic        dat_valid = 1'b0;
    logic [31:0] dat_word = '0;
    logic        acc_valid = 1'b0;
    logic        acc_store = 1'b0;
    logic [2:0]  acc_set = '0;
    logic        acc_way = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        rpt_valid;
    logic        rpt_ready = 1'b0;
    logic        rpt_rw;
    logic [2:0]  rpt_set;
    logic        rpt_way;
    logic [15:0] rpt_begin_ts;
    logic [31:0] rpt_begin_hash;
    logic [15:0] rpt_end_ts;
    logic [31:0] rpt_end_hash;
    logic        err_flag;
    logic [15:0] err_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;
    always @(negedge clk) now_ts <= now_ts + 16'd1;

    coh_epoch_tracker i_coh_epoch_tracker (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind),
        .evt_set(evt_set), .evt_way(evt_way), .now_ts(now_ts),
        .dat_valid(dat_valid), .dat_word(dat_word),
        .acc_valid(acc_valid), .acc_store(acc_store), .acc_set(acc_set),
        .acc_way(acc_way), .acc_addr(acc_addr),
        .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_rw(rpt_rw),
        .rpt_set(rpt_set), .rpt_way(rpt_way),
        .rpt_begin_ts(rpt_begin_ts), .rpt_begin_hash(rpt_begin_hash),
        .rpt_end_ts(rpt_end_ts), .rpt_end_hash(rpt_end_hash),
        .err_flag(err_flag), .err_addr(err_addr)
    );

    task automatic expect_eq(input string tag, input string what,
                             input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // hash per the requirement text: shift in each word MSB first
    function automatic logic [31:0] hash_word(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r = c;
        logic [31:0] d = w;
        repeat (32) begin
            if (r[31] != d[31]) r = (r << 1) ^ 32'h04C1_1DB7;
            else                r = r << 1;
            d = d << 1;
        end
        return r;
    endfunction

    function automatic logic [31:0] blk_word(input logic [31:0] base, input int j);
        return base + 32'h1357_9BDF * j;
    endfunction

    function automatic logic [31:0] blk_hash(input logic [31:0] base);
        logic [31:0] h = 32'hFFFF_FFFF;
        for (int j = 0; j < 4; j++) h = hash_word(h, blk_word(base, j));
        return h;
    endfunction

    // ---------------- behavioural reference model ----------------
    typedef struct packed {
        logic        rw;
        logic [2:0]  set;
        logic        way;
        logic [15:0] bts;
        logic [31:0] bh;
        logic [15:0] ets;
        logic [31:0] eh;
    } rep_t;

    rep_t        m_q[$];
    bit          m_open [16];
    bit          m_rw   [16];
    logic [15:0] m_bts  [16];
    logic [31:0] m_bh   [16];
    int          m_phase;
    int          m_cnt;
    int          m_kind;
    int          m_idx;
    int          m_ai;
    logic [15:0] m_ts;
    logic [31:0] m_crc;
    bit          m_err;
    logic [15:0] m_err_addr;
    bit          m_rdy;
    rep_t        m_rep;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.delete();
            for (int e = 0; e < 16; e++) begin
                m_open[e] = 0; m_rw[e] = 0; m_bts[e] = '0; m_bh[e] = '0;
            end
            m_phase = 0; m_cnt = 0; m_err = 0; m_err_addr = '0;
        end else begin
            m_rdy = (m_phase == 0) && (m_q.size() < DEPTH);
            if (acc_valid) begin
                m_ai = acc_set * 2 + acc_way;
                if ((!m_open[m_ai] || (acc_store && !m_rw[m_ai])) && !m_err) begin
                    m_err = 1; m_err_addr = acc_addr;
                end
            end
            if (m_q.size() > 0 && rpt_ready) void'(m_q.pop_front());
            case (m_phase)
                0: if (evt_valid && m_rdy) begin
                    m_kind = evt_kind; m_idx = evt_set * 2 + evt_way;
                    m_ts = now_ts; m_crc = 32'hFFFF_FFFF; m_cnt = 0; m_phase = 1;
                end
                1: if (dat_valid) begin
                    m_crc = hash_word(m_crc, dat_word);
                    m_cnt++;
                    if (m_cnt == 4) m_phase = 2;
                end
                default: begin
                    m_rep = '{rw: m_rw[m_idx], set: 3'(m_idx / 2), way: 1'(m_idx % 2),
                              bts: m_bts[m_idx], bh: m_bh[m_idx], ets: m_ts, eh: m_crc};
                    if (m_kind >= 2 && m_open[m_idx]) m_q.push_back(m_rep);
                    if (m_kind == 2) begin
                        m_open[m_idx] = 0;
                    end else begin
                        m_open[m_idx] = 1;
                        m_rw[m_idx]   = (m_kind != 0);
                        m_bts[m_idx]  = m_ts;
                        m_bh[m_idx]   = m_crc;
                    end
                    m_phase = 0;
                end
            endcase
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            expect_eq("R2", "evt_ready", 64'(evt_ready), 64'((m_phase == 0) && (m_q.size() < DEPTH)));
            expect_eq("R5", "rpt_valid", 64'(rpt_valid), 64'(m_q.size() > 0));
            if (m_q.size() > 0) begin
                expect_eq("R5", "rpt_rw",   64'(rpt_rw),  64'(m_q[0].rw));
                expect_eq("R5", "rpt_set",  64'(rpt_set), 64'(m_q[0].set));
                expect_eq("R5", "rpt_way",  64'(rpt_way), 64'(m_q[0].way));
                expect_eq("R4", "begin_ts", 64'(rpt_begin_ts), 64'(m_q[0].bts));
                expect_eq("R4", "begin_hash", 64'(rpt_begin_hash), 64'(m_q[0].bh));
                expect_eq("R5", "end_ts",   64'(rpt_end_ts), 64'(m_q[0].ets));
                expect_eq("R3", "end_hash", 64'(rpt_end_hash), 64'(m_q[0].eh));
            end
            expect_eq("R8", "err_flag", 64'(err_flag), 64'(m_err));
            expect_eq("R8", "err_addr", 64'(err_addr), 64'(m_err_addr));
        end
    end

    // ---------------- stimulus tasks (called at a negedge) ----------------
    task automatic send_event(input logic [1:0] k, input logic [2:0] s, input logic w,
                              input logic [31:0] base, input bit gap);
        evt_valid = 1'b1; evt_kind = k; evt_set = s; evt_way = w;
        while (!evt_ready) @(negedge clk);
        @(negedge clk);
        evt_valid = 1'b0;
        for (int j = 0; j < 4; j++) begin
            if (gap && j == 2) begin
                dat_valid = 1'b0; dat_word = 32'hDEAD_0000;
                @(negedge clk);
            end
            dat_valid = 1'b1; dat_word = blk_word(base, j);
            @(negedge clk);
        end
        dat_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic access(input bit st, input logic [2:0] s, input logic w, input logic [15:0] a);
        acc_valid = 1'b1; acc_store = st; acc_set = s; acc_way = w; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic take_report(output rep_t r);
        int n = 0;
        while (!rpt_valid && n < 50) begin @(negedge clk); n++; end
        expect_eq("R9", "report present", 64'(rpt_valid), 64'd1);
        r = '{rw: rpt_rw, set: rpt_set, way: rpt_way, bts: rpt_begin_ts,
              bh: rpt_begin_hash, ets: rpt_end_ts, eh: rpt_end_hash};
        rpt_ready = 1'b1;
        @(negedge clk);
        rpt_ready = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_all();
        rep_t r1, r2;
        do_reset();
        // R1 reset values
        expect_eq("R1", "evt_ready", 64'(evt_ready), 64'd1);
        expect_eq("R1", "rpt_valid", 64'(rpt_valid), 64'd0);
        expect_eq("R1", "err_flag",  64'(err_flag),  64'd0);
        expect_eq("R1", "err_addr",  64'(err_addr),  64'd0);

        // R4 grants, one with a gap in the word stream (R2)
        send_event(2'd0, 3'd1, 1'b0, 32'h1111_0000, 1'b1);
        send_event(2'd1, 3'd2, 1'b1, 32'h2222_0000, 1'b0);
        send_event(2'd0, 3'd0, 1'b0, 32'h0A0A_0000, 1'b0);
        // R7 legal accesses
        access(1'b0, 3'd1, 1'b0, 16'h0100);
        access(1'b0, 3'd2, 1'b1, 16'h0200);
        access(1'b1, 3'd2, 1'b1, 16'h0204);
        @(negedge clk);
        expect_eq("R7", "no error on legal accesses", 64'(err_flag), 64'd0);

        // R5 revoke with report
        send_event(2'd2, 3'd1, 1'b0, 32'h3333_0000, 1'b0);
        take_report(r1);
        expect_eq("R5", "report rw", 64'(r1.rw), 64'd0);
        expect_eq("R5", "report set", 64'(r1.set), 64'd1);
        expect_eq("R3", "begin hash", 64'(r1.bh), 64'(blk_hash(32'h1111_0000)));
        expect_eq("R3", "end hash", 64'(r1.eh), 64'(blk_hash(32'h3333_0000)));
        // R5 revoke of an empty entry
        send_event(2'd2, 3'd3, 1'b1, 32'h4444_0000, 1'b0);
        repeat (3) @(negedge clk);
        expect_eq("R5", "no report for empty entry", 64'(rpt_valid), 64'd0);

        // R6 upgrade then revoke
        send_event(2'd0, 3'd4, 1'b1, 32'h5555_0000, 1'b0);
        send_event(2'd3, 3'd4, 1'b1, 32'h6666_0000, 1'b0);
        take_report(r1);
        access(1'b1, 3'd4, 1'b1, 16'h0400);
        @(negedge clk);
        expect_eq("R6", "store after upgrade legal", 64'(err_flag), 64'd0);
        send_event(2'd2, 3'd4, 1'b1, 32'h7777_0000, 1'b0);
        take_report(r2);
        expect_eq("R6", "upgrade closes read-only", 64'(r1.rw), 64'd0);
        expect_eq("R6", "upgrade end hash", 64'(r1.eh), 64'(blk_hash(32'h6666_0000)));
        expect_eq("R6", "new epoch read-write", 64'(r2.rw), 64'd1);
        expect_eq("R6", "begin ts equals end ts", 64'(r2.bts), 64'(r1.ets));
        expect_eq("R6", "begin hash equals end hash", 64'(r2.bh), 64'(r1.eh));

        // R10 back-pressure with a full queue, R9 ordering
        send_event(2'd0, 3'd5, 1'b0, 32'h8888_0000, 1'b0);
        send_event(2'd1, 3'd6, 1'b0, 32'h9999_0000, 1'b0);
        send_event(2'd2, 3'd5, 1'b0, 32'hAAAA_0000, 1'b0);
        send_event(2'd2, 3'd6, 1'b0, 32'hBBBB_0000, 1'b0);
        evt_valid = 1'b1; evt_kind = 2'd0; evt_set = 3'd7; evt_way = 1'b0;
        repeat (4) begin
            @(negedge clk);
            expect_eq("R10", "evt_ready while full", 64'(evt_ready), 64'd0);
        end
        evt_valid = 1'b0;
        take_report(r1);
        take_report(r2);
        expect_eq("R9", "first report order", 64'(r1.set), 64'd5);
        expect_eq("R9", "second report order", 64'(r2.set), 64'd6);
        expect_eq("R9", "second report rw", 64'(r2.rw), 64'd1);

        // R8 sticky error, first address kept
        access(1'b0, 3'd7, 1'b1, 16'hBEEF);
        expect_eq("R8", "error set", 64'(err_flag), 64'd1);
        expect_eq("R8", "error address", 64'(err_addr), 64'hBEEF);
        access(1'b1, 3'd0, 1'b0, 16'h1234);
        repeat (2) @(negedge clk);
        expect_eq("R8", "error stays", 64'(err_flag), 64'd1);
        expect_eq("R8", "first address kept", 64'(err_addr), 64'hBEEF);

        // R1 entries empty after reset
        do_reset();
        access(1'b0, 3'd0, 1'b0, 16'h5555);
        expect_eq("R1", "entry empty after reset", 64'(err_flag), 64'd1);
        // R7 store to a read-only epoch
        do_reset();
        send_event(2'd0, 3'd2, 1'b0, 32'hCCCC_0000, 1'b0);
        access(1'b0, 3'd2, 1'b0, 16'h0600);
        access(1'b1, 3'd2, 1'b0, 16'h0604);
        expect_eq("R7", "store in read-only epoch", 64'(err_flag), 64'd1);
        expect_eq("R7", "store address", 64'(err_addr), 64'h0604);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule